// File: doc/BRIEF.md
# I2C Master Line Condition Controller

This block sits between the serial shifter of a port running as an I2C master and the SCL and SDA pins. Software writes request bits to ask for a start, a repeated start or a stop condition. The block produces each condition as a short sequence of line states, one bit-rate tick per state. When the condition is finished, the block clears the request bit by itself.

Software also decides what drives the lines. The lines can carry either the generated bus conditions or the shifter's clock and data. When the shifter drives the lines, SDA can instead carry a programmed acknowledge level. SCL can be parked high or forced low. SDA can be delayed by a programmable number of count-source ticks of the baud generator.

Two registers are written through a one-bit address. Address 0 is the control register. Address 1 holds the SDA delay setting. Two tick inputs set the timing: `bitTick` paces the phases of a condition, and `srcTick` is the count source used for the SDA delay.

Top module: `i2cLineCond`

## Requirements
- R1: After reset all control fields are 0, the delay setting is 0 and `reqState` is 000. SCL and SDA then follow `serClk` and `serData` directly, with no added latency.
- R2: Control register bits [0], [1] and [2] request start, restart and stop, and each shows on `reqState` at the same position. A write of 1 sets the bit on the next clock. A write of 0 leaves a pending bit unchanged.
- R3: A start condition, beginning from both lines high, drives SDA low while SCL stays high, and then drives SCL low.
- R4: A stop condition drives both lines low, then raises SCL with SDA still low, and then raises SDA.
- R5: A repeated start first drives SCL low with SDA high, then raises SCL, and then runs the start sequence.
- R6: Each line state of a condition is held for exactly one `bitTick` period. The request bit clears only on a `bitTick`, one tick after the last state.
- R7: When several requests are pending, stop runs first, then restart, then start. Only one condition runs at a time, and at most one request bit clears in any cycle.
- R8: Control bit [3] is the condition select. At 0, SCL follows `serClk`, SDA follows the data source, and pending requests wait. At 1, the generated condition states drive both lines.
- R9: With the condition select at 0 and bit [5] (ACK select) at 1, SDA carries bit [4]: 0 for ACK, 1 for NACK. With bit [5] at 0, SDA carries `serData`.
- R10: Control bit [6] stops SCL output and holds `sclOut` at 1 from the cycle after the write.
- R11: Control bit [7] holds `sclOut` at 0 from the cycle after the write, and it takes precedence over bit [6]. Clearing it releases SCL.
- R12: Delay register bits [2:0] = n. At n = 0, SDA passes through with no delay. For n from 1 to 7, a change of SDA appears after the first `srcTick` following the change plus n more ticks, so the delay lies between n and n+1 count-source periods. `sdaOut` then moves only on a `srcTick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Register select: 0 control, 1 SDA delay |
| wrData | input | 8 | Write data |
| bitTick | input | 1 | One-cycle pulse per bit period, paces condition phases |
| srcTick | input | 1 | One-cycle pulse per baud count-source period |
| serClk | input | 1 | Serial clock from the shifter |
| serData | input | 1 | Serial data from the shifter |
| sclOut | output | 1 | SCL line drive |
| sdaOut | output | 1 | SDA line drive |
| reqState | output | 3 | Pending requests: [0] start, [1] restart, [2] stop |

## Verification
A wrong phase register shows up as an unexpected SCL/SDA pair at the ports. It appears within one `bitTick` of the wrong transition, and a scoreboard of the expected line changes, with their spacing, catches it. A request bit that fails to clear, or that clears in the wrong order, stays visible on `reqState`. It is checked right after each condition ends. A fault in the delay counter moves the SDA edge outside the window of n to n+1 count-source periods, and this shows on the first data change after the delay is set.

// File: rtl/i2cCondPkg.sv
package i2cCondPkg;

  localparam int DLY_W = 3;
  localparam int REQ_N = 3;

  // request bit positions (also the reqState order)
  localparam int REQ_START   = 0;
  localparam int REQ_RESTART = 1;
  localparam int REQ_STOP    = 2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_S0, PH_S1, PH_S2, PH_R0, PH_P0, PH_P1, PH_P2
  } phase_e;

  typedef struct packed {
    logic             condSel;
    logic             ackBit;
    logic             ackSel;
    logic             sclStop;
    logic             sclWait;
    logic [DLY_W-1:0] sdaDly;
  } cfg_t;

  typedef struct packed {
    logic load;
    logic scl;
    logic sda;
  } strobe_t;

endpackage

// File: rtl/i2cSdaDelay.sv
module i2cSdaDelay #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DLY_W-1:0] dly,
  input  logic             srcTick,
  input  logic             dIn,
  output logic             dOut
);

  logic             pendVal;
  logic             held;
  logic [DLY_W-1:0] cnt;

  // the tick in the change cycle is skipped; the first later tick starts
  // the count and n further ticks move the value to the output
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendVal <= 1'b1;
      held    <= 1'b1;
      cnt     <= '0;
    end else if (dly == '0) begin
      pendVal <= dIn;
      held    <= dIn;
      cnt     <= '0;
    end else if (dIn != pendVal) begin
      pendVal <= dIn;
      cnt     <= '0;
    end else if (srcTick && (pendVal != held)) begin
      if (cnt == dly) begin
        held <= pendVal;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign dOut = (dly == '0) ? dIn : held;

endmodule

// File: rtl/i2cCondCtrl.sv
module i2cCondCtrl
  import i2cCondPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              bitTick,
  output cfg_t              cfg,
  output strobe_t           strb,
  output logic [REQ_N-1:0]  reqState
);

  localparam logic ADDR_CTRL = 1'b0;
  localparam int   B_COND = 3;
  localparam int   B_ACKD = 4;
  localparam int   B_ACKS = 5;
  localparam int   B_STOP = 6;
  localparam int   B_WAIT = 7;

  cfg_t             cfgQ;
  phase_e           ph, phNxt;
  logic [REQ_N-1:0] reqBits, curMask, curNxt, clrMask, setMask;
  logic             done;

  function automatic logic [1:0] phaseLines(phase_e p);
    case (p)
      PH_S0:   return 2'b11;
      PH_S1:   return 2'b10;
      PH_S2:   return 2'b00;
      PH_R0:   return 2'b01;
      PH_P0:   return 2'b00;
      PH_P1:   return 2'b10;
      PH_P2:   return 2'b11;
      default: return 2'b11;
    endcase
  endfunction

  always_comb begin
    phNxt  = ph;
    curNxt = curMask;
    done   = 1'b0;
    if (bitTick) begin
      case (ph)
        PH_IDLE: begin
          if (cfgQ.condSel) begin
            if (reqBits[REQ_STOP]) begin
              phNxt  = PH_P0;
              curNxt = REQ_N'(1) << REQ_STOP;
            end else if (reqBits[REQ_RESTART]) begin
              phNxt  = PH_R0;
              curNxt = REQ_N'(1) << REQ_RESTART;
            end else if (reqBits[REQ_START]) begin
              phNxt  = PH_S0;
              curNxt = REQ_N'(1) << REQ_START;
            end
          end
        end
        PH_R0: phNxt = PH_S0;
        PH_S0: phNxt = PH_S1;
        PH_S1: phNxt = PH_S2;
        PH_P0: phNxt = PH_P1;
        PH_P1: phNxt = PH_P2;
        PH_S2, PH_P2: begin
          phNxt = PH_IDLE;
          done  = 1'b1;
        end
        default: phNxt = PH_IDLE;
      endcase
    end
  end

  assign clrMask = done ? curMask : '0;
  assign setMask = (wrEn && wrAddr == ADDR_CTRL) ? wrData[REQ_N-1:0] : '0;

  assign strb.load = bitTick && (phNxt != PH_IDLE);
  assign {strb.scl, strb.sda} = phaseLines(phNxt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqBits <= '0;
      cfgQ    <= '0;
      ph      <= PH_IDLE;
      curMask <= '0;
    end else begin
      reqBits <= (reqBits & ~clrMask) | setMask;
      ph      <= phNxt;
      curMask <= curNxt;
      if (wrEn) begin
        if (wrAddr == ADDR_CTRL) begin
          cfgQ.condSel <= wrData[B_COND];
          cfgQ.ackBit  <= wrData[B_ACKD];
          cfgQ.ackSel  <= wrData[B_ACKS];
          cfgQ.sclStop <= wrData[B_STOP];
          cfgQ.sclWait <= wrData[B_WAIT];
        end else begin
          cfgQ.sdaDly <= wrData[DLY_W-1:0];
        end
      end
    end
  end

  assign cfg      = cfgQ;
  assign reqState = reqBits;

endmodule

// File: rtl/i2cCondPath.sv
module i2cCondPath
  import i2cCondPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  cfg_t    cfg,
  input  strobe_t strb,
  input  logic    srcTick,
  input  logic    serClk,
  input  logic    serData,
  output logic    sclOut,
  output logic    sdaOut
);

  logic condScl, condSda;
  logic sclSel, sdaSrc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      condScl <= 1'b1;
      condSda <= 1'b1;
    end else if (strb.load) begin
      condScl <= strb.scl;
      condSda <= strb.sda;
    end
  end

  assign sclSel = cfg.condSel ? condScl : serClk;
  assign sclOut = cfg.sclWait ? 1'b0 : (cfg.sclStop ? 1'b1 : sclSel);
  assign sdaSrc = cfg.condSel ? condSda : (cfg.ackSel ? cfg.ackBit : serData);

  i2cSdaDelay #(.DLY_W(DLY_W)) uDelay (
    .clk     (clk),
    .rstN    (rstN),
    .dly     (cfg.sdaDly),
    .srcTick (srcTick),
    .dIn     (sdaSrc),
    .dOut    (sdaOut)
  );

endmodule

// File: rtl/i2cLineCond.sv
module i2cLineCond
  import i2cCondPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              bitTick,
  input  logic              srcTick,
  input  logic              serClk,
  input  logic              serData,
  output logic              sclOut,
  output logic              sdaOut,
  output logic [REQ_N-1:0]  reqState
);

  cfg_t    cfgBus;
  strobe_t strbBus;

  i2cCondCtrl #(.DATA_W(DATA_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .bitTick  (bitTick),
    .cfg      (cfgBus),
    .strb     (strbBus),
    .reqState (reqState)
  );

  i2cCondPath uPath (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfgBus),
    .strb    (strbBus),
    .srcTick (srcTick),
    .serClk  (serClk),
    .serData (serData),
    .sclOut  (sclOut),
    .sdaOut  (sdaOut)
  );

endmodule

// File: rtl/i2cLineCondChk.sv
module i2cLineCondChk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       wrAddr,
  input logic [7:0] wrData,
  input logic       bitTick,
  input logic       srcTick,
  input logic [2:0] reqState,
  input logic       sclOut,
  input logic       sdaOut,
  input logic [2:0] dlyCfg
);

  AST_REQ_SET_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAddr && wrData[2:0] != 3'b000) |=>
      ((reqState & $past(wrData[2:0])) == $past(wrData[2:0]))); // R2

  AST_REQ_CLEAR_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(reqState) & ~reqState)) |-> $past(bitTick)); // R6

  AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0($past(reqState) & ~reqState)); // R7

  AST_STOP_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAddr && wrData[6] && !wrData[7]) |=> sclOut); // R10

  AST_WAIT_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAddr && wrData[7]) |=> !sclOut); // R11

  AST_DELAY_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (dlyCfg != 3'd0 && $past(dlyCfg) != 3'd0 && sdaOut != $past(sdaOut))
      |-> $past(srcTick)); // R12

endmodule

bind i2cLineCond i2cLineCondChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .bitTick  (bitTick),
  .srcTick  (srcTick),
  .reqState (reqState),
  .sclOut   (sclOut),
  .sdaOut   (sdaOut),
  .dlyCfg   (cfgBus.sdaDly)
);

// File: tb/i2cLineCond_test.sv
module i2cLineCond_test;

  localparam int BITP = 16;
  localparam int SRCP = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn, wrAddr;
  logic [7:0] wrData;
  logic       bitTick = 1'b0, srcTick = 1'b0;
  logic       serClk, serData;
  logic       sclOut, sdaOut;
  logic [2:0] reqState;

  int nChk = 0, nFail = 0, cyc = 0, divCnt = 0, lastCyc = 0;
  bit finished = 0, monOn = 0;
  logic prevScl, prevSda;

  typedef struct {
    logic  scl;
    logic  sda;
    int    gap;
    string tag;
  } item_t;
  item_t sbQ[$];

  i2cLineCond uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .bitTick(bitTick), .srcTick(srcTick), .serClk(serClk), .serData(serData),
    .sclOut(sclOut), .sdaOut(sdaOut), .reqState(reqState)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    divCnt  = divCnt + 1;
    bitTick = (divCnt % BITP) == 0;
    srcTick = (divCnt % SRCP) == 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkRange(input string tag, input int act, input int lo, input int hi);
    nChk++;
    if (act < lo || act > hi) begin
      nFail++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  // scoreboard monitor: every line change pops one expected item
  always @(negedge clk) begin
    item_t it;
    if (monOn && (sclOut !== prevScl || sdaOut !== prevSda)) begin
      if (sbQ.size() == 0) begin
        nChk++;
        nFail++;
        $display("FAIL SB: actual=%b%b expected=no change", sclOut, sdaOut);
      end else begin
        it = sbQ.pop_front();
        chk({it.tag, " lines"}, {30'd0, sclOut, sdaOut}, {30'd0, it.scl, it.sda});
        if (it.gap != 0) chk({it.tag, " phase length"}, cyc - lastCyc, it.gap);
      end
      lastCyc = cyc;
    end
    prevScl = sclOut;
    prevSda = sdaOut;
  end

  task automatic expItem(input logic s, input logic d, input int g, input string tag);
    item_t it;
    it.scl = s; it.sda = d; it.gap = g; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitMask(input logic [2:0] m, input string tag);
    int n = 0;
    while ((reqState & m) != 3'b000 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " request cleared"}, int'(reqState & m), 0);
  endtask

  task automatic measDly(input logic v, input int lo, input int hi, input string tag);
    int k = 0;
    @(negedge clk);
    serData = v;
    #0.1;
    while (sdaOut !== v && k < 100) begin
      @(negedge clk);
      k++;
    end
    chkRange(tag, k, lo, hi);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL WDOG: actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = 1'b0; wrData = '0;
    serClk = 1'b1; serData = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state and direct pass-through
    chk("R1 reqState", reqState, 0);
    chk("R1 scl", sclOut, 1);
    chk("R1 sda", sdaOut, 1);
    serClk = 1'b0; serData = 1'b0; #0.1;
    chk("R1 scl follows serClk", sclOut, 0);
    chk("R1 sda follows serData", sdaOut, 0);
    serClk = 1'b1; serData = 1'b1;

    // R2 set by writing 1, R8 waits while condition select is 0
    wr(1'b0, 8'h00);
    chk("R2 no request", reqState, 0);
    wr(1'b0, 8'h01);
    chk("R2 start set", reqState, 3'b001);
    repeat (64) @(negedge clk);
    chk("R8 request waits", reqState, 3'b001);
    chk("R8 scl from serClk", sclOut, 1);
    chk("R8 sda from serData", sdaOut, 1);
    wr(1'b0, 8'h00);
    chk("R2 zero write ignored", reqState, 3'b001);

    // R3 start condition
    prevScl = sclOut; prevSda = sdaOut; monOn = 1'b1;
    expItem(1, 0, 0, "R3");
    expItem(0, 0, BITP, "R3/R6");
    wr(1'b0, 8'h08);
    waitMask(3'b111, "R6 start");
    chk("R3 scoreboard drained", sbQ.size(), 0);

    // R4 stop condition
    expItem(1, 0, 0, "R4");
    expItem(1, 1, BITP, "R4/R6");
    wr(1'b0, 8'h0C);
    waitMask(3'b111, "R6 stop");
    chk("R4 scoreboard drained", sbQ.size(), 0);

    // R5 restart from idle-high lines
    expItem(0, 1, 0, "R5");
    expItem(1, 1, BITP, "R5/R6");
    expItem(1, 0, BITP, "R5/R6");
    expItem(0, 0, BITP, "R5/R6");
    wr(1'b0, 8'h0A);
    waitMask(3'b111, "R6 restart");
    chk("R5 scoreboard drained", sbQ.size(), 0);

    // R7 all three requested at once
    expItem(1, 0, 0, "R7 stop");
    expItem(1, 1, BITP, "R7 stop");
    expItem(0, 1, 0, "R7 restart");
    expItem(1, 1, BITP, "R7 restart");
    expItem(1, 0, BITP, "R7 restart");
    expItem(0, 0, BITP, "R7 restart");
    expItem(1, 1, 0, "R7 start");
    expItem(1, 0, BITP, "R7 start");
    expItem(0, 0, BITP, "R7 start");
    wr(1'b0, 8'h0F);
    waitMask(3'b100, "R7 stop first");
    chk("R7 after stop", reqState, 3'b011);
    waitMask(3'b010, "R7 restart second");
    chk("R7 after restart", reqState, 3'b001);
    waitMask(3'b111, "R7 start last");
    chk("R7 scoreboard drained", sbQ.size(), 0);
    monOn = 1'b0;

    // R8 back to serial source
    wr(1'b0, 8'h00);
    chk("R8 scl back to serClk", sclOut, 1);
    chk("R8 sda back to serData", sdaOut, 1);

    // R9 acknowledge select
    wr(1'b0, 8'h20);
    chk("R9 ACK level", sdaOut, 0);
    serData = 1'b0;
    wr(1'b0, 8'h30);
    chk("R9 NACK level", sdaOut, 1);
    wr(1'b0, 8'h00);
    chk("R9 serial data again", sdaOut, 0);
    serData = 1'b1;

    // R10 and R11 SCL stop and wait
    serClk = 1'b0;
    wr(1'b0, 8'h40);
    chk("R10 scl stopped high", sclOut, 1);
    serClk = 1'b1;
    wr(1'b0, 8'hC0);
    chk("R11 wait beats stop", sclOut, 0);
    wr(1'b0, 8'h00);
    chk("R11 released", sclOut, 1);
    serClk = 1'b0; #0.1;
    chk("R11 scl follows after release", sclOut, 0);
    serClk = 1'b1;

    // R12 SDA delay
    wr(1'b1, 8'h03);
    repeat (40) @(negedge clk);
    measDly(1'b0, 3 * SRCP + 2, 4 * SRCP + 1, "R12 delay3 fall");
    repeat (40) @(negedge clk);
    measDly(1'b1, 3 * SRCP + 2, 4 * SRCP + 1, "R12 delay3 rise");
    wr(1'b1, 8'h01);
    repeat (40) @(negedge clk);
    measDly(1'b0, SRCP + 2, 2 * SRCP + 1, "R12 delay1 fall");
    repeat (40) @(negedge clk);
    wr(1'b1, 8'h00);
    serData = 1'b1; #0.1;
    chk("R12 zero delay direct", sdaOut, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule